// File: doc/BRIEF.md
# Programmable Interval Counter Channel

A single binary down-counting timer channel for a larger timer subsystem. It counts only on cycles where the `tick` clock-enable is high. A `gate` input and one `out` line tie it to the rest of the system. A parent block writes a new initial count and a 3-bit mode code with a one-cycle `load` strobe. The parent reads the live count from `count`. Latching, byte sequencing and the host register interface are handled outside this block.

Six waveforms are available:
- a terminal-count flag that stays high;
- a gate-retriggered one-shot;
- a periodic single-tick rate pulse;
- a square wave;
- a software-started one-tick strobe;
- a gate-started one-tick strobe.

A loaded count of zero stands for 65536. After reset the channel runs as a square wave of period 65536. The system decides the reset level of each channel's gate: typically high for the first two channels and low for the third.

Top module: `interval_counter`

## Requirements
- R1: While reset is held, and until the first counting tick after it, the channel is in mode 3 with count 65536. This means `out` = 1 and `count` = 0.
- R2: A loaded value of 0 acts as an initial count N of 65536. In mode 0 `out` rises only after 65536 counting ticks.
- R3: `load` restarts timing, taking elapsed ticks d to 0. In the next cycle `count` equals the loaded value. `load` has priority over a same-cycle gate edge and tick.
- R4: Mode 0: `out` = (d >= N), so it goes high after N ticks and stays high; `count` = (N - d) mod 65536.
- R5: Mode 1: `out` = (d < N); the gate never holds counting, and a gate rising edge sets d to 0.
- R6: Mode 2: `count` = N - (d mod N); `out` is 1 only when d mod N = 0 and d is not 0.
- R7: Mode 3: `out` = ((d mod N) < (N+1)/2), using integer division; `count` = N - ((2d) mod N), read modulo 65536.
- R8: Modes 4 and 5: `out` = (d == N), a single pulse per start; in mode 5 a gate rising edge sets d to 0.
- R9: In modes 0, 2, 3 and 4, a tick while `gate` is low is ignored and `count` holds. In modes 1 and 5 ticks count whatever the gate level.
- R10: A gate rising edge is `gate` high in a cycle after a cycle in which it was low; the gate is taken as low out of reset. A rising edge sets d to 0 in modes 1, 2, 3 and 5, and has no effect on d in modes 0 and 4.
- R11: In modes 0, 1, 4 and 5 `count` keeps decrementing past zero and wraps modulo 65536.
- R12: Mode codes 6 and 7 behave exactly as modes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Counting clock-enable |
| gate | input | 1 | Gate level; rising edges retrigger where the mode says |
| load | input | 1 | One-cycle strobe taking load_value and load_mode |
| load_value | input | 16 | Initial count (0 means 65536) |
| load_mode | input | 3 | Mode code 0..7 |
| out | output | 1 | Channel output line |
| count | output | 16 | Live count value |

## Verification
Odd counts in the square wave are a target. A design that splits the period the wrong way would hold the high phase one tick too short, and one that wraps the doubled count wrongly would show values above N. The one-shot modes are run far past expiry, so a counter that saturates at zero rather than wrapping would show up there. Gate edges are applied in every mode. An edge wrongly taken as a restart in modes 0 or 4, or a level wrongly taken as an enable in modes 1 or 5, moves the output timing. A full 65536-tick run checks the zero-count case, where a truncated count would expire at once.

// File: rtl/interval_counter.sv
module interval_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          gate,
  input  logic          load,
  input  logic [CW-1:0] load_value,
  input  logic [2:0]    load_mode,
  output logic          out,
  output logic [CW-1:0] count
);
  localparam int NW = CW + 1;
  localparam logic [NW-1:0] FULL = {1'b1, {CW{1'b0}}};
  localparam logic [NW-1:0] ONE  = {{(NW-1){1'b0}}, 1'b1};
  localparam logic [CW-1:0] DEC  = {{(CW-1){1'b0}}, 1'b1};

  logic [2:0]    mode_q;
  logic [NW-1:0] n_q, e_q, e_nx, half;
  logic [NW:0]   dbl, dbl_mod, cnt_full;
  logic [CW-1:0] dc_q;
  logic          ran_q, gate_q;

  wire rise      = gate & ~gate_q;
  wire gate_free = (mode_q == 3'd1) || (mode_q == 3'd5);
  wire periodic  = (mode_q == 3'd2) || (mode_q == 3'd3);
  wire retrig    = gate_free || periodic;
  wire run       = tick & (gate | gate_free);

  wire [NW-1:0] n_new    = (load_value == '0) ? FULL : {1'b0, load_value};
  wire [2:0]    mode_new = (load_mode[2:1] == 2'b11) ? {1'b0, load_mode[1:0]} : load_mode;

  always_comb begin
    if (periodic)
      e_nx = (e_q == n_q - ONE) ? '0 : e_q + ONE;
    else
      e_nx = (e_q > n_q) ? e_q : e_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 3'd3;
      n_q    <= FULL;
      e_q    <= '0;
      dc_q   <= '0;
      ran_q  <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      gate_q <= gate;
      if (load) begin
        mode_q <= mode_new;
        n_q    <= n_new;
        e_q    <= '0;
        dc_q   <= load_value;
        ran_q  <= 1'b0;
      end else if (rise && retrig) begin
        e_q    <= '0;
        dc_q   <= n_q[CW-1:0];
        ran_q  <= 1'b0;
      end else if (run) begin
        e_q    <= e_nx;
        dc_q   <= dc_q - DEC;
        ran_q  <= 1'b1;
      end
    end
  end

  assign half    = (n_q + ONE) >> 1;
  assign dbl     = {e_q, 1'b0};
  assign dbl_mod = (dbl >= {1'b0, n_q}) ? dbl - {1'b0, n_q} : dbl;

  always_comb begin
    case (mode_q)
      3'd2:    cnt_full = {1'b0, n_q} - {1'b0, e_q};
      3'd3:    cnt_full = {1'b0, n_q} - dbl_mod;
      default: cnt_full = {2'b00, dc_q};
    endcase
  end
  assign count = cnt_full[CW-1:0];

  always_comb begin
    case (mode_q)
      3'd0:       out = (e_q >= n_q);
      3'd1:       out = (e_q < n_q);
      3'd2:       out = (e_q == '0) && ran_q;
      3'd3:       out = (e_q < half);
      3'd4, 3'd5: out = (e_q == n_q);
      default:    out = 1'b0;
    endcase
  end
endmodule

module interval_counter_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          gate,
  input logic          load,
  input logic [CW-1:0] load_value,
  input logic [2:0]    mode_q,
  input logic          gate_q,
  input logic          out,
  input logic [CW-1:0] count
);
  localparam logic [CW-1:0] UNIT = {{(CW-1){1'b0}}, 1'b1};

  // R3
  load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == $past(load_value));

  // R4
  m0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd0 && out && !load) |=> out);

  // R9
  m0_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd0 && !gate && !load) |=> $stable(count));

  // R6
  m2_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd2 && out && tick && gate && gate_q && !load && count != UNIT) |=> !out);

  // R8
  m4_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd4 && out && tick && gate && !load) |=> !out);
endmodule

bind interval_counter interval_counter_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate), .load(load),
  .load_value(load_value), .mode_q(mode_q), .gate_q(gate_q),
  .out(out), .count(count)
);

// File: tb/sim_interval_counter.sv
module sim_interval_counter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, gate = 1'b0, load = 1'b0;
  logic [15:0] load_value = '0;
  logic [2:0]  load_mode = '0;
  logic out;
  logic [15:0] count;

  int nchk = 0, nfail = 0;
  string tag = "R1";
  bit finished = 0;

  int md, nn, dd;
  bit gq;

  always #10 clk = ~clk;

  interval_counter u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate), .load(load),
    .load_value(load_value), .load_mode(load_mode), .out(out), .count(count)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      md = 3; nn = 65536; dd = 0; gq = 0;
    end else begin
      if (load) begin
        nn = (load_value == 0) ? 65536 : int'(load_value);
        md = (load_mode >= 6) ? int'(load_mode) - 4 : int'(load_mode);
        dd = 0;
      end else if (gate && !gq && (md == 1 || md == 2 || md == 3 || md == 5))
        dd = 0;
      else if (tick && (gate || md == 1 || md == 5))
        dd = dd + 1;
      gq = gate;
    end
  end

  function automatic bit exp_out();
    case (md)
      0: return dd >= nn;
      1: return dd < nn;
      2: return (dd % nn == 0) && (dd != 0);
      3: return (dd % nn) < (nn + 1) / 2;
      default: return dd == nn;
    endcase
  endfunction

  function automatic int exp_cnt();
    case (md)
      2: return (nn - dd % nn) & 32'hFFFF;
      3: return (nn - (2 * dd) % nn) & 32'hFFFF;
      default: return (nn - dd) & 32'hFFFF;
    endcase
  endfunction

  task automatic check();
    if (!rst_n) return;
    nchk++;
    if (out !== exp_out() || int'(count) != exp_cnt()) begin
      nfail++;
      $display("FAIL %s: out=%0b count=%0d expected out=%0b count=%0d",
               tag, out, count, exp_out(), exp_cnt());
    end
  endtask

  task automatic step(input logic t, input logic g, input logic ld,
                      input logic [15:0] v, input logic [2:0] m);
    @(negedge clk);
    check();
    tick = t; gate = g; load = ld; load_value = v; load_mode = m;
  endtask

  task automatic run(input int n, input int tper, input logic g);
    for (int i = 0; i < n; i++) step((i % tper) == 0, g, 1'b0, 16'd0, 3'd0);
  endtask

  task automatic ld(input logic [15:0] v, input logic [2:0] m, input logic g);
    step(1'b1, g, 1'b1, v, m);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state then square wave of 65536
    tag = "R1"; run(6, 1, 1'b1);
    // R4 terminal count, R11 wrap beyond expiry
    tag = "R4"; ld(16'd5, 3'd0, 1'b1); run(8, 1, 1'b1);
    tag = "R11"; run(10, 1, 1'b1);
    // R9 gate low freezes mode 0 and mode 2
    tag = "R9"; ld(16'd6, 3'd0, 1'b1); run(3, 1, 1'b1); run(4, 1, 1'b0); run(8, 1, 1'b1);
    ld(16'd4, 3'd2, 1'b1); run(3, 1, 1'b1); run(4, 1, 1'b0);
    // R10 rising edge restarts mode 2, not mode 0 or 4
    tag = "R10"; run(6, 1, 1'b1);
    ld(16'd4, 3'd0, 1'b0); run(3, 1, 1'b0); run(6, 1, 1'b1);
    ld(16'd5, 3'd4, 1'b1); run(2, 1, 1'b1); run(1, 1, 1'b0); run(7, 1, 1'b1);
    // R5 one-shot with retrigger; gate level does not hold it
    tag = "R5"; ld(16'd4, 3'd1, 1'b0); run(6, 1, 1'b0);
    run(2, 1, 1'b1); run(1, 1, 1'b0); run(2, 1, 1'b1); run(1, 1, 1'b0); run(8, 1, 1'b1);
    run(12, 1, 1'b0);
    // R6 rate generator, dense and sparse ticks
    tag = "R6"; ld(16'd3, 3'd2, 1'b1); run(12, 1, 1'b1); run(15, 3, 1'b1);
    ld(16'd1, 3'd2, 1'b1); run(4, 1, 1'b1);
    // R7 square wave, odd and even counts
    tag = "R7"; ld(16'd5, 3'd3, 1'b1); run(15, 1, 1'b1);
    ld(16'd4, 3'd3, 1'b1); run(12, 1, 1'b1); run(12, 2, 1'b1);
    run(1, 1, 1'b0); run(8, 1, 1'b1);
    ld(16'd1, 3'd3, 1'b1); run(3, 1, 1'b1);
    // R8 software and gate-started strobes
    tag = "R8"; ld(16'd3, 3'd4, 1'b1); run(8, 1, 1'b1);
    ld(16'd3, 3'd5, 1'b0); run(4, 1, 1'b0); run(6, 1, 1'b1);
    run(1, 1, 1'b0); run(6, 2, 1'b1);
    // R12 aliases
    tag = "R12"; ld(16'd3, 3'd6, 1'b1); run(8, 1, 1'b1);
    ld(16'd6, 3'd7, 1'b1); run(10, 1, 1'b1);
    // R3 reload mid-run, load beating a same-cycle gate edge
    tag = "R3"; ld(16'd7, 3'd2, 1'b1); run(3, 1, 1'b1);
    ld(16'd9, 3'd1, 1'b1); run(2, 1, 1'b0);
    ld(16'd2, 3'd3, 1'b1); run(6, 1, 1'b1);
    // R2 zero count means 65536
    tag = "R2"; ld(16'd0, 3'd2, 1'b1); run(5, 1, 1'b1);
    ld(16'd0, 3'd0, 1'b1); run(65540, 1, 1'b1);
    finished = 1;
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      report();
    end
  end
endmodule